// File: doc/BRIEF.md
# DSP Condition Status Register with T-Flag Forwarding

This block holds the condition flags of a DSP arithmetic unit in one 32-bit register. Each time the datapath completes an operation, it raises a valid strobe. On that strobe the block captures five condition flags: carry/borrow, negative, zero, overflow and signed-greater. They come from the operation result, from a compare indication, and from the raw carry and overflow bits that the datapath supplies.

The block can also forward one chosen condition to the processor's single-bit T flag. The forwarding is set up through a 3-bit selector field and an enable bit, both of which software writes through a plain register port. When forwarding is enabled, every executed unconditional DSP operation produces a T-flag write-enable and value in the same cycle. An instruction marked as conditional never touches T. A reserved selector code also leaves T alone.

Software sees the whole register through a readback port and may overwrite every implemented bit. When a software write and a hardware update fall in the same cycle, the software write takes precedence.

Top module: `dsp_cond_status`

## Requirements
- R1: Bits 31:12 and bits 3:1 of the readback always read 0, and writing ones to them has no effect.
- R2: A register write loads the selector from wdata bits 11:9, the enable from bit 8, GT from bit 7, Z from bit 6, N from bit 5, V from bit 4 and C from bit 0. The new value is visible on the readback one cycle later.
- R3: On a valid operation with no write in that cycle, bit 0 captures the raw carry, bit 4 captures the raw overflow and bit 5 captures the result's most significant bit.
- R4: On a valid operation, bit 6 (Z) captures result == 0 for a non-compare operation and the equal indication for a compare operation.
- R5: On a valid operation, bit 7 (GT) captures "result positive and nonzero" for a non-compare operation and the greater indication for a compare operation.
- R6: Without a valid strobe or a write, the register keeps its value.
- R7: When a write and a valid operation fall in the same cycle, the register takes the written value.
- R8: While the enable bit is 0, t_we stays 0.
- R9: When the enable bit is 1 and an unconditional valid operation occurs, t_we is 1 in that same cycle. t_val is then the condition of the current operation that the selector picks: 0 carry, 1 negative, 2 zero, 3 overflow, 4 signed greater, 5 signed greater-or-equal (GT OR Z).
- R10: A valid operation with op_cond = 1 never asserts t_we. Its flags are still captured.
- R11: With selector code 6 or 7, t_we stays 0.
- R12: After reset the readback is 0 and t_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Software write strobe |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Register readback |
| op_valid | input | 1 | A DSP operation completes this cycle |
| op_cond | input | 1 | The operation is conditionally executed |
| op_result | input | DATA_W | Operation result |
| op_is_cmp | input | 1 | The operation is a compare |
| cmp_gt | input | 1 | Compare: operand 1 greater than operand 2 |
| cmp_eq | input | 1 | Compare: operands equal |
| raw_carry | input | 1 | Carry/borrow from the datapath |
| raw_ovf | input | 1 | Overflow from the datapath |
| t_we | output | 1 | T-flag write enable |
| t_val | output | 1 | T-flag value |

## Verification
The assertions check these properties on every cycle:
- The reserved bits read zero.
- t_we never rises for an invalid or conditional operation, or with a reserved selector.
- The register holds its value when idle.
- A software write lands exactly as written.
- GT and Z are never both set after a non-compare update.

Only the bench's scenarios can show the rest. That covers the value routed to T for each of the six selector codes, and the flag values that follow from particular results and compare indications. It also covers the gating by the enable bit and the precedence of a write over a same-cycle update, which the bench checks against its own reference model.

// File: rtl/dsp_cond_pkg.sv
package dsp_cond_pkg;

    localparam int REG_W  = 32;
    localparam int SEL_LO = 9;
    localparam int SEL_HI = 11;
    localparam int EN_POS = 8;
    localparam int GT_POS = 7;
    localparam int Z_POS  = 6;
    localparam int N_POS  = 5;
    localparam int V_POS  = 4;
    localparam int C_POS  = 0;

    typedef enum logic [2:0] {
        TSEL_CARRY = 3'd0,
        TSEL_NEG   = 3'd1,
        TSEL_ZERO  = 3'd2,
        TSEL_OVF   = 3'd3,
        TSEL_GT    = 3'd4,
        TSEL_GE    = 3'd5,
        TSEL_RSV6  = 3'd6,
        TSEL_RSV7  = 3'd7
    } tsel_e;

    typedef struct packed {
        logic gt;
        logic z;
        logic n;
        logic v;
        logic c;
    } cond_t;

    typedef struct packed {
        tsel_e sel;
        logic  en;
        cond_t flags;
    } state_t;

    function automatic logic [REG_W-1:0] pack_state(input state_t s);
        logic [REG_W-1:0] w;
        w                 = '0;
        w[SEL_HI:SEL_LO]  = s.sel;
        w[EN_POS]         = s.en;
        w[GT_POS]         = s.flags.gt;
        w[Z_POS]          = s.flags.z;
        w[N_POS]          = s.flags.n;
        w[V_POS]          = s.flags.v;
        w[C_POS]          = s.flags.c;
        return w;
    endfunction

    function automatic state_t unpack_word(input logic [REG_W-1:0] w);
        state_t s;
        s.sel      = tsel_e'(w[SEL_HI:SEL_LO]);
        s.en       = w[EN_POS];
        s.flags.gt = w[GT_POS];
        s.flags.z  = w[Z_POS];
        s.flags.n  = w[N_POS];
        s.flags.v  = w[V_POS];
        s.flags.c  = w[C_POS];
        return s;
    endfunction

endpackage

// File: rtl/dsp_cond_flag_eval.sv
module dsp_cond_flag_eval
    import dsp_cond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    input  logic              is_cmp,
    input  logic              cmp_gt,
    input  logic              cmp_eq,
    input  logic              carry,
    input  logic              ovf,
    output cond_t             cond
);
    localparam int MSB = DATA_W - 1;

    logic res_neg;
    logic res_zero;
    logic res_pos;

    always_comb begin
        res_neg  = result[MSB];
        res_zero = (result == '0);
        res_pos  = !res_neg && !res_zero;
        cond.c   = carry;
        cond.v   = ovf;
        cond.n   = res_neg;
        cond.z   = is_cmp ? cmp_eq : res_zero;
        cond.gt  = is_cmp ? cmp_gt : res_pos;
    end

endmodule

// File: rtl/dsp_cond_tsel.sv
module dsp_cond_tsel
    import dsp_cond_pkg::*;
(
    input  tsel_e sel,
    input  logic  en,
    input  logic  valid,
    input  logic  cond_instr,
    input  cond_t cur,
    output logic  t_we,
    output logic  t_val
);
    logic sel_ok;

    always_comb begin
        sel_ok = 1'b1;
        t_val  = 1'b0;
        case (sel)
            TSEL_CARRY: t_val = cur.c;
            TSEL_NEG:   t_val = cur.n;
            TSEL_ZERO:  t_val = cur.z;
            TSEL_OVF:   t_val = cur.v;
            TSEL_GT:    t_val = cur.gt;
            TSEL_GE:    t_val = cur.gt | cur.z;
            default:    sel_ok = 1'b0;
        endcase
        t_we = valid && en && !cond_instr && sel_ok;
    end

endmodule

// File: rtl/dsp_cond_regs.sv
module dsp_cond_regs
    import dsp_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [REG_W-1:0] sw_wdata,
    input  logic             hw_we,
    input  cond_t            hw_flags,
    output state_t           st_q
);
    state_t st_d;

    always_comb begin
        st_d = st_q;
        if (sw_we) begin
            st_d = unpack_word(sw_wdata);
        end else if (hw_we) begin
            st_d.flags = hw_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dsp_cond_status.sv
module dsp_cond_status
    import dsp_cond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              op_valid,
    input  logic              op_cond,
    input  logic [DATA_W-1:0] op_result,
    input  logic              op_is_cmp,
    input  logic              cmp_gt,
    input  logic              cmp_eq,
    input  logic              raw_carry,
    input  logic              raw_ovf,
    output logic              t_we,
    output logic              t_val
);
    cond_t  cur_flags;
    state_t st_q;

    dsp_cond_flag_eval #(.DATA_W(DATA_W)) u_eval (
        .result (op_result),
        .is_cmp (op_is_cmp),
        .cmp_gt (cmp_gt),
        .cmp_eq (cmp_eq),
        .carry  (raw_carry),
        .ovf    (raw_ovf),
        .cond   (cur_flags)
    );

    dsp_cond_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (reg_we),
        .sw_wdata (reg_wdata),
        .hw_we    (op_valid),
        .hw_flags (cur_flags),
        .st_q     (st_q)
    );

    dsp_cond_tsel u_tsel (
        .sel        (st_q.sel),
        .en         (st_q.en),
        .valid      (op_valid),
        .cond_instr (op_cond),
        .cur        (cur_flags),
        .t_we       (t_we),
        .t_val      (t_val)
    );

    always_comb reg_rdata = pack_state(st_q);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:12] == '0) && (reg_rdata[3:1] == '0));

    // R10
    t_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_we |-> (op_valid && !op_cond));

    // R11
    t_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_we |-> (reg_rdata[11:9] < 3'd6));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !reg_we) |=> $stable(reg_rdata));

    // R2
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata == ($past(reg_wdata) & 32'h0000_0FF1)));

    // R5
    gt_z_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_is_cmp && !reg_we) |=> !(reg_rdata[7] && reg_rdata[6]));

endmodule

// File: tb/dsp_cond_status_bench.sv
module dsp_cond_status_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        op_valid = 1'b0;
    logic        op_cond = 1'b0;
    logic [31:0] op_result = '0;
    logic        op_is_cmp = 1'b0;
    logic        cmp_gt = 1'b0;
    logic        cmp_eq = 1'b0;
    logic        raw_carry = 1'b0;
    logic        raw_ovf = 1'b0;
    logic        t_we;
    logic        t_val;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];

    logic [2:0] m_sel = '0;
    logic       m_en = 1'b0;
    logic       m_gt = 1'b0, m_z = 1'b0, m_n = 1'b0, m_v = 1'b0, m_c = 1'b0;

    always #4 clk = ~clk;

    dsp_cond_status u_dsp_cond_status (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .op_valid(op_valid), .op_cond(op_cond),
        .op_result(op_result), .op_is_cmp(op_is_cmp), .cmp_gt(cmp_gt),
        .cmp_eq(cmp_eq), .raw_carry(raw_carry), .raw_ovf(raw_ovf),
        .t_we(t_we), .t_val(t_val)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] m_word();
        return {20'd0, m_sel, m_en, m_gt, m_z, m_n, m_v, 3'd0, m_c};
    endfunction

    task automatic push(input int due, input int kind, input logic [31:0] exp, input string req);
        item_t it;
        it.due = due; it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // Driver: drives one cycle, pushes expectations, advances the model.
    task automatic step(input logic we, input logic [31:0] wd, input logic v, input logic c,
                        input logic [31:0] res, input logic cmp, input logic gt, input logic eq,
                        input logic cy, input logic ov, input string treq, input string rreq);
        logic e_gt, e_z, e_n, e_tv, e_we;
        reg_we = we; reg_wdata = wd; op_valid = v; op_cond = c; op_result = res;
        op_is_cmp = cmp; cmp_gt = gt; cmp_eq = eq; raw_carry = cy; raw_ovf = ov;
        e_n  = res[31];
        e_z  = cmp ? eq : (res == 32'd0);
        e_gt = cmp ? gt : (!res[31] && res != 32'd0);
        case (m_sel)
            3'd0: e_tv = cy;
            3'd1: e_tv = e_n;
            3'd2: e_tv = e_z;
            3'd3: e_tv = ov;
            3'd4: e_tv = e_gt;
            3'd5: e_tv = e_gt | e_z;
            default: e_tv = 1'b0;
        endcase
        e_we = v && m_en && !c && (m_sel < 3'd6);
        push(cyc, 1, {31'd0, e_we}, treq);
        if (e_we) push(cyc, 2, {31'd0, e_tv}, treq);
        if (we) begin
            m_sel = wd[11:9]; m_en = wd[8]; m_gt = wd[7]; m_z = wd[6];
            m_n = wd[5]; m_v = wd[4]; m_c = wd[0];
        end else if (v) begin
            m_gt = e_gt; m_z = e_z; m_n = e_n; m_v = ov; m_c = cy;
        end
        push(cyc + 1, 0, m_word(), rreq);
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] wd, input string req);
        step(1'b1, wd, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req, req);
    endtask

    task automatic op(input logic c, input logic [31:0] res, input logic cmp, input logic gt,
                      input logic eq, input logic cy, input logic ov, input string treq);
        step(1'b0, 32'd0, 1'b1, c, res, cmp, gt, eq, cy, ov, treq, "R3 R4 R5");
    endtask

    // Monitor: pops due items and compares them with the outputs.
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = reg_rdata;
                    1: act = {31'd0, t_we};
                    default: act = {31'd0, t_val};
                endcase
                tests++;
                if (act !== it.exp || it.due != cyc) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h cyc=%0d", it.req, it.kind, act, it.exp, cyc);
                end
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        tests++;
        if (reg_rdata !== 32'd0 || t_we !== 1'b0) begin
            fails++;
            $display("FAIL R12 actual=%h/%b expected=0/0", reg_rdata, t_we);
        end
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 R2: all ones written, only implemented bits stick
        wr(32'hFFFF_FFFF, "R1 R2");
        wr(32'h0000_0000, "R2");
        wr(32'h0000_0AB1, "R2");
        // R6 idle hold
        step(1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6", "R6");
        step(1'b0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6", "R6");
        // R8 enable off: no T update
        wr(32'h0000_0000, "R8");
        op(1'b0, 32'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        op(1'b0, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
        // R9 / R11: every selector code against several operations
        for (int s = 0; s < 8; s++) begin
            string tq;
            tq = (s < 6) ? "R9" : "R11";
            wr((32'(s) << 9) | 32'h100, "R2");
            op(1'b0, 32'd5,         1'b0, 1'b0, 1'b0, 1'b1, 1'b0, tq);
            op(1'b0, 32'd0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b1, tq);
            op(1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, tq);
            op(1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tq);
            op(1'b0, 32'd7,         1'b1, 1'b0, 1'b1, 1'b0, 1'b0, tq);
            op(1'b0, 32'd3,         1'b1, 1'b0, 1'b0, 1'b1, 1'b1, tq);
        end
        // R10: conditional operation leaves T alone, flags still captured
        wr(32'h0000_0100, "R10");
        op(1'b1, 32'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
        op(1'b1, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        // R7: write and update in one cycle, write wins
        step(1'b1, 32'h0000_0A50, 1'b1, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7", "R7");
        step(1'b1, 32'h0000_0001, 1'b1, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7", "R7");
        step(1'b0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6", "R6");
        repeat (3) @(posedge clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule